// File: doc/BRIEF.md
# Buzzer Tone and Base-Tick Generator

This block turns a source clock, modelled as a single-cycle enable pulse on `src_tick`, into a 32 kHz base tick for neighbouring timer and display logic. It also produces a complementary pair of buzzer outputs for driving a piezo element differentially. The source can be a 32 kHz crystal, which passes straight through, or one of two 256 kHz sources, either internal or external, which are divided by eight. The selection arrives as a two-bit code on `src_sel`.

The command decoder sits outside this block. It sends single-cycle pulses to switch the tone on or off and to choose between the higher (4 kHz) and lower (2 kHz) tone. This block keeps the tone state and the frequency choice in its own registers. A system-enable level stops everything: no base ticks are produced and both buzzer pins are held low. At reset the tone is off and the lower frequency is chosen.

Top module: `buzz_tone_unit`

## Requirements
- R1: With `src_sel` = 0 (crystal), every sampled `src_tick` gives one `base_tick` pulse on the following cycle.
- R2: With `src_sel` = 1 (internal 256 kHz), 2 (external 256 kHz) or 3 (treated as external), exactly one `base_tick` is produced per 8 sampled source ticks.
- R3: While `sys_en` is low, there is no `base_tick`, both buzzer pins are low in the same cycle, and the prescaler restarts. After `sys_en` rises in a 256 kHz mode, the first `base_tick` follows the 8th source tick. The tone state set by commands is kept.
- R4: While the tone sounds, `bz_p` has a 50% duty cycle. Its period is 8 base ticks for the 4 kHz choice and 16 base ticks for the 2 kHz choice.
- R5: A `tone_hi_cmd` pulse selects 4 kHz and a `tone_lo_cmd` pulse selects 2 kHz. If both arrive in the same cycle, 2 kHz wins. Neither pulse turns the tone on or off.
- R6: A `tone_on_cmd` pulse starts the tone and a `tone_off_cmd` pulse stops it. If both arrive in the same cycle, off wins. Neither pulse changes the frequency choice.
- R7: While the tone sounds, exactly one of `bz_p` and `bz_n` is high, and the two pins are never high together. When the tone is off, both are low.
- R8: When the tone starts, `bz_n` goes high first. `bz_p` rises only after a full half-period, which is 4 base ticks at 4 kHz and 8 base ticks at 2 kHz.
- R9: After reset, `base_tick`, `bz_p` and `bz_n` are low, the tone is off, and the 2 kHz frequency is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_en | input | 1 | System enable level |
| src_sel | input | 2 | Source code: 0 crystal, 1 internal 256 kHz, 2 external 256 kHz, 3 as external |
| src_tick | input | 1 | One-cycle pulse at the selected source rate |
| tone_on_cmd | input | 1 | Pulse: start the tone |
| tone_off_cmd | input | 1 | Pulse: stop the tone |
| tone_hi_cmd | input | 1 | Pulse: choose 4 kHz |
| tone_lo_cmd | input | 1 | Pulse: choose 2 kHz |
| base_tick | output | 1 | One-cycle 32 kHz enable pulse |
| bz_p | output | 1 | Buzzer pin, true phase |
| bz_n | output | 1 | Buzzer pin, complement phase |

## Verification
The hardest case to reach from the ports is the prescaler restart after `sys_en` drops and rises again in a 256 kHz mode. Here the residue of the divide-by-eight count is invisible at the pins, and only the distance from re-enable to the first base tick reveals it. The bench keeps its own count of the source pulses the design samples. It snapshots that count at re-enable and checks that exactly eight pulses pass before `base_tick`. Tone rates are measured by counting edges and high cycles over windows that span whole periods, so the count is exact whatever the starting phase. The length of the first half-period is measured in base ticks from the moment the tone starts.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_RC   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_sel_e;
endpackage

// File: rtl/buzz_prescaler.sv
module buzz_prescaler
  import buzz_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_en,
  input  logic [1:0] src_sel,
  input  logic       src_tick,
  output logic       base_tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d;
  logic         fast_src;

  assign fast_src = (src_sel != SRC_XTAL);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!sys_en) begin
      cnt_d = '0;
    end else if (src_tick) begin
      if (fast_src) begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          tick_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign base_tick = tick_q;

  p_xtal_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en && src_tick && src_sel == SRC_XTAL) |=> base_tick);
  p_tick_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> $past(src_tick));
  p_off_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en |=> !base_tick);
endmodule

// File: rtl/buzz_cmd_state.sv
module buzz_cmd_state (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_on_cmd,
  input  logic tone_off_cmd,
  input  logic tone_hi_cmd,
  input  logic tone_lo_cmd,
  output logic tone_on,
  output logic sel_hi
);
  logic on_q, on_d;
  logic hi_q, hi_d;

  always_comb begin
    on_d = on_q;
    if (tone_off_cmd)     on_d = 1'b0;
    else if (tone_on_cmd) on_d = 1'b1;
    hi_d = hi_q;
    if (tone_lo_cmd)      hi_d = 1'b0;
    else if (tone_hi_cmd) hi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      on_q <= on_d;
      hi_q <= hi_d;
    end
  end

  assign tone_on = on_q;
  assign sel_hi  = hi_q;

  p_off_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tone_off_cmd |=> !tone_on);
  p_lo_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tone_lo_cmd |=> !sel_hi);
  p_freq_keeps_onoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_on_cmd && !tone_off_cmd) |=> $stable(tone_on));
endmodule

// File: rtl/buzz_tone_div.sv
module buzz_tone_div #(
  parameter int HALF_HI = 4,
  parameter int HALF_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic base_tick,
  input  logic sel_hi,
  output logic bz_p,
  output logic bz_n
);
  localparam int HALF_MAX = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
  localparam int CW = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
  localparam logic [CW-1:0] LAST_HI = CW'(HALF_HI - 1);
  localparam logic [CW-1:0] LAST_LO = CW'(HALF_LO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] half_last;
  logic          ph_q, ph_d;

  assign half_last = sel_hi ? LAST_HI : LAST_LO;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!act) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (base_tick) begin
      if (cnt_q >= half_last) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign bz_p = act & ph_q;
  assign bz_n = act & ~ph_q;

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (cnt_q == '0 && !ph_q));
  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !base_tick) |=> (!act || $stable(ph_q)));
endmodule

// File: rtl/buzz_tone_unit.sv
module buzz_tone_unit #(
  parameter int PRE_DIV     = 8,
  parameter int HALF_HI     = 4,
  parameter int HALF_LO     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_en,
  input  logic [1:0] src_sel,
  input  logic       src_tick,
  input  logic       tone_on_cmd,
  input  logic       tone_off_cmd,
  input  logic       tone_hi_cmd,
  input  logic       tone_lo_cmd,
  output logic       base_tick,
  output logic       bz_p,
  output logic       bz_n
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   tone_on;
  logic                   sel_hi;
  logic                   act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  buzz_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sys_en   (sys_en),
    .src_sel  (src_sel),
    .src_tick (src_tick),
    .base_tick(base_tick)
  );

  buzz_cmd_state u_cmd (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tone_on_cmd (tone_on_cmd),
    .tone_off_cmd(tone_off_cmd),
    .tone_hi_cmd (tone_hi_cmd),
    .tone_lo_cmd (tone_lo_cmd),
    .tone_on     (tone_on),
    .sel_hi      (sel_hi)
  );

  assign act = sys_en & tone_on;

  buzz_tone_div #(.HALF_HI(HALF_HI), .HALF_LO(HALF_LO)) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .act      (act),
    .base_tick(base_tick),
    .sel_hi   (sel_hi),
    .bz_p     (bz_p),
    .bz_n     (bz_n)
  );

  p_silent_when_off_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sys_en && !$past(sys_en)) |-> (!bz_p && !bz_n && !base_tick));
endmodule

// File: tb/buzz_tone_unit_tb.sv
`timescale 1ns/1ps
module buzz_tone_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic       src_tick = 1'b0;
  logic       tone_on_cmd = 1'b0, tone_off_cmd = 1'b0;
  logic       tone_hi_cmd = 1'b0, tone_lo_cmd = 1'b0;
  logic       base_tick, bz_p, bz_n;

  int checks = 0;
  int errors = 0;
  int src_cnt = 0;
  int gen_cnt = 0;

  always #2.5 clk = ~clk;

  buzz_tone_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .src_sel(src_sel),
    .src_tick(src_tick), .tone_on_cmd(tone_on_cmd), .tone_off_cmd(tone_off_cmd),
    .tone_hi_cmd(tone_hi_cmd), .tone_lo_cmd(tone_lo_cmd),
    .base_tick(base_tick), .bz_p(bz_p), .bz_n(bz_n)
  );

  // Source pulse every 4 clocks; src_cnt counts pulses sampled by the design.
  always @(posedge clk) begin
    #1;
    if (src_tick) src_cnt++;
    gen_cnt = (gen_cnt + 1) % 4;
    src_tick = (gen_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic pulse(input bit on_c, input bit off_c, input bit hi_c, input bit lo_c);
    @(negedge clk);
    tone_on_cmd = on_c; tone_off_cmd = off_c; tone_hi_cmd = hi_c; tone_lo_cmd = lo_c;
    @(negedge clk);
    tone_on_cmd = 0; tone_off_cmd = 0; tone_hi_cmd = 0; tone_lo_cmd = 0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts base ticks and pin activity over n cycles.
  task automatic measure(input int n, output int ticks, output int rp, output int rn,
                         output int hi, output int both);
    logic pp, pn;
    ticks = 0; rp = 0; rn = 0; hi = 0; both = 0;
    pp = bz_p; pn = bz_n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (base_tick) ticks++;
      if (bz_p && !pp) rp++;
      if (bz_n && !pn) rn++;
      if (bz_p) hi++;
      if (bz_p && bz_n) both++;
      pp = bz_p; pn = bz_n;
    end
  endtask

  task automatic t_reset_state;
    int t, rp, rn, hi, both;
    chk(base_tick == 0, "R9 base_tick after reset", base_tick, 0);
    chk(bz_p == 0 && bz_n == 0, "R9 pins low after reset", {bz_p, bz_n}, 0);
    @(negedge clk); sys_en = 1; src_sel = 2'd0;
    wait_cycles(4);
    measure(128, t, rp, rn, hi, both);
    chk(rp + rn + hi == 0, "R9 tone off by default", rp + rn + hi, 0);
  endtask

  task automatic t_base_rate(input logic [1:0] sel, input int exp_t, input string tag);
    int t, rp, rn, hi, both;
    @(negedge clk); src_sel = sel;
    wait_cycles(40);
    measure(256, t, rp, rn, hi, both);
    chk(t == exp_t, tag, t, exp_t);
  endtask

  task automatic t_tone_rate(input logic [1:0] sel, input bit use_hi, input bit send_freq,
                             input int win, input int exp_r, input string tag);
    int t, rp, rn, hi, both;
    @(negedge clk); src_sel = sel;
    wait_cycles(40);
    pulse(0, 1, 0, 0);
    if (send_freq) pulse(0, 0, use_hi, !use_hi);
    pulse(1, 0, 0, 0);
    measure(win, t, rp, rn, hi, both);
    chk(rp == exp_r, {"R4 bz_p rises ", tag}, rp, exp_r);
    chk(rn == exp_r, {"R7 bz_n rises ", tag}, rn, exp_r);
    chk(hi == win / 2, {"R4 duty ", tag}, hi, win / 2);
    chk(both == 0, {"R7 never both high ", tag}, both, 0);
  endtask

  task automatic t_first_half(input logic [1:0] sel, input bit use_hi, input int exp_n);
    int n = 0;
    @(negedge clk); src_sel = sel;
    wait_cycles(40);
    pulse(0, 1, 0, 0);
    pulse(0, 0, use_hi, !use_hi);
    pulse(1, 0, 0, 0);
    chk(bz_n == 1 && bz_p == 0, "R8 bz_n leads at start", {bz_p, bz_n}, 1);
    for (int i = 0; i < 2000; i++) begin
      if (bz_p) break;
      if (base_tick && bz_n) n++;
      @(negedge clk);
    end
    chk(n == exp_n, "R8 first half-period length", n, exp_n);
  endtask

  task automatic t_priority;
    int t, rp, rn, hi, both;
    @(negedge clk); src_sel = 2'd0;
    pulse(0, 1, 0, 0);
    pulse(1, 1, 0, 0);
    measure(64, t, rp, rn, hi, both);
    chk(rp + rn + hi == 0, "R6 off wins over on", rp + rn + hi, 0);
    pulse(0, 0, 1, 1);
    measure(64, t, rp, rn, hi, both);
    chk(rp + rn + hi == 0, "R5 freq cmd leaves tone off", rp + rn + hi, 0);
    pulse(1, 0, 0, 0);
    measure(256, t, rp, rn, hi, both);
    chk(rp == 4, "R5 low wins when both freq cmds", rp, 4);
  endtask

  task automatic t_onoff_keeps_freq;
    int t, rp, rn, hi, both;
    pulse(0, 1, 0, 0);
    pulse(0, 0, 1, 0);
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    pulse(1, 0, 0, 0);
    measure(256, t, rp, rn, hi, both);
    chk(rp == 8, "R6 on/off keeps 4 kHz choice", rp, 8);
  endtask

  task automatic t_sys_off;
    int t, rp, rn, hi, both, snap, d;
    bit seen;
    @(negedge clk); src_sel = 2'd1;
    pulse(1, 0, 0, 0);
    wait_cycles(50);
    sys_en = 0;
    @(negedge clk);
    chk(bz_p == 0 && bz_n == 0, "R3 pins low at disable", {bz_p, bz_n}, 0);
    measure(256, t, rp, rn, hi, both);
    chk(t == 0, "R3 no base ticks while disabled", t, 0);
    chk(rp + rn + hi == 0, "R3 pins stay low while disabled", rp + rn + hi, 0);
    sys_en = 1;
    snap = src_cnt;
    @(negedge clk);
    chk(bz_n == 1, "R3 tone state kept over disable", bz_n, 1);
    seen = 0; d = -1;
    for (int i = 0; i < 200; i++) begin
      if (base_tick) begin seen = 1; d = src_cnt - snap; break; end
      @(negedge clk);
    end
    chk(seen && d == 8, "R3 prescaler restarts after enable", d, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(5);
    rst_n = 1;
    wait_cycles(5);
    t_reset_state();
    t_tone_rate(2'd0, 0, 0, 256, 4, "R9 default 2 kHz crystal");
    t_base_rate(2'd0, 64, "R1 crystal pass-through");
    t_base_rate(2'd1, 8, "R2 internal divide by 8");
    t_base_rate(2'd2, 8, "R2 external divide by 8");
    t_base_rate(2'd3, 8, "R2 code 3 divide by 8");
    t_base_rate(2'd0, 64, "R1 back to crystal");
    t_tone_rate(2'd0, 1, 1, 256, 8, "4k crystal");
    t_tone_rate(2'd0, 0, 1, 256, 4, "2k crystal");
    t_tone_rate(2'd1, 1, 1, 2048, 8, "4k internal");
    t_tone_rate(2'd2, 0, 1, 2048, 4, "2k external");
    t_first_half(2'd0, 1, 4);
    t_first_half(2'd1, 0, 8);
    t_priority();
    t_onoff_keeps_freq();
    t_sys_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule